// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address stream for a four-beat memory burst. A load captures a full starting address; each later advance steps a small beat index, and the output address is the captured address with its lowest bits replaced by a value derived from the starting low bits and the beat index. The upper address bits never move during a burst.

Two orderings are offered, chosen by a static mode input. In interleaved order the low bits of beat k are the starting low bits XOR k. In linear order they are the starting low bits plus k, wrapping within the burst window. The mode input is applied combinationally to the stored state, so the output follows it in the same cycle. A clock enable freezes the whole sequencer when low, which lets the surrounding pipeline insert wait states without losing its place in a burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the stored address and beat index clear, so addr_out reads 0 afterwards.
- R2: A clock edge with clk_en=1 and load=1 captures start_addr; in the following cycle addr_out equals start_addr in either ordering (beat 0).
- R3: With interleave=1, beat k (k advances after a load) shows low two bits equal to the loaded low bits XOR k.
- R4: With interleave=0, beat k shows low two bits equal to the loaded low bits plus k, modulo 4.
- R5: After four advances the beat index wraps to 0 and addr_out again equals the loaded address.
- R6: Advances never change addr_out bits above the two low bits; those stay at their loaded value.
- R7: When clk_en=0, load and advance are ignored and addr_out holds (for an unchanged interleave).
- R8: When load and advance are both high with clk_en=1, the load wins and the beat index restarts at 0.
- R9: interleave acts on the current beat without changing the stored index: toggling it mid-burst with no advance changes addr_out in the same cycle, and toggling it back restores the earlier value.
- R10: With clk_en=1 and neither load nor advance, addr_out holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Clock enable; 0 holds all state |
| load | input | 1 | Capture start_addr and restart the burst |
| advance | input | 1 | Step to the next beat of the burst |
| start_addr | input | ADDR_W | Starting address for a load |
| interleave | input | 1 | Ordering select: 1 XOR order, 0 modulo-add order |
| addr_out | output | ADDR_W | Current burst address |

## Verification
The hardest situation to reach is a change of ordering in the middle of a burst, because it only shows up when the beat index is non-zero and the two orderings disagree for the loaded low bits. The stimulus loads a start whose low bits are 01, advances once so the index is 1 (linear gives 10, interleaved gives 00), then flips the mode with no advance and flips it back, checking that the output moves and then returns. Load-versus-advance priority and clock-enable hold are reached by asserting conflicting strobes in the same cycle and checking the output does not step.

// File: rtl/burst_pkg.sv
// Shared definitions for the burst address sequencer.
// Assumes a power-of-two burst length addressed by the lowest address bits.
package burst_pkg;

    // Ordering selected by the mode input.
    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;

    // Default number of low address bits covered by a burst.
    localparam int unsigned BURST_IDX_W = 2;

endpackage

// File: rtl/burst_base_reg.sv
// Holds the address captured by the most recent load.
// Assumes load is only meaningful when en is high.
module burst_base_reg #(
    parameter int unsigned ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);

    // Capture the starting address on an enabled load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en && load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/burst_index_ctr.sv
// Beat index of the burst: cleared by load, stepped by advance, wraps naturally.
// Assumes load has priority over advance.
module burst_index_ctr #(
    parameter int unsigned IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic             advance,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

    // Restart on load, step on advance, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (en) begin
            if (load) begin
                idx <= '0;
            end else if (advance) begin
                idx <= idx + IDX_ONE;
            end
        end
    end

endmodule

// File: rtl/burst_order_map.sv
// Combinational map from starting low bits and beat index to the beat's low bits.
// Assumes the mode is static or changes only between beats; it is not registered.
module burst_order_map
    import burst_pkg::*;
#(
    parameter int unsigned IDX_W = 2
) (
    input  logic             mode,
    input  logic [IDX_W-1:0] start_lo,
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] beat_lo
);

    logic [IDX_W-1:0] lo_xor;
    logic [IDX_W-1:0] lo_add;

    // Per-bit XOR for the interleaved order.
    for (genvar b = 0; b < IDX_W; b++) begin : g_xor
        assign lo_xor[b] = start_lo[b] ^ idx[b];
    end

    // Modulo add for the linear order; carry out is dropped.
    assign lo_add = start_lo + idx;

    // Select the ordering.
    always_comb begin
        if (burst_order_e'(mode) == ORDER_INTERLEAVED) begin
            beat_lo = lo_xor;
        end else begin
            beat_lo = lo_add;
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Burst address sequencer top: base register, beat index and ordering map.
// Assumes ADDR_W > IDX_W; upper bits come straight from the base register.
module burst_addr_seq
    import burst_pkg::*;
#(
    parameter int unsigned ADDR_W = 21,
    parameter int unsigned IDX_W  = BURST_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              interleave,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int unsigned HI_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  beat_lo;

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (clk_en),
        .load  (load),
        .d     (start_addr),
        .q     (base_q)
    );

    burst_index_ctr #(.IDX_W(IDX_W)) u_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (clk_en),
        .load    (load),
        .advance (advance),
        .idx     (idx_q)
    );

    burst_order_map #(.IDX_W(IDX_W)) u_map (
        .mode     (interleave),
        .start_lo (base_q[IDX_W-1:0]),
        .idx      (idx_q),
        .beat_lo  (beat_lo)
    );

    // Join the fixed upper bits with the sequenced low bits.
    assign addr_out = {base_q[ADDR_W-1 -: HI_W], beat_lo};

endmodule

// File: rtl/burst_addr_seq_chk.sv
// Port-level checker for the burst address sequencer, bound to every instance.
module burst_addr_seq_chk #(
    parameter int unsigned ADDR_W = 21,
    parameter int unsigned IDX_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              load,
    input logic              advance,
    input logic [ADDR_W-1:0] start_addr,
    input logic              interleave,
    input logic [ADDR_W-1:0] addr_out
);

    AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && load) |=> (addr_out == $past(start_addr))); // R2

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && advance && !load && !interleave) |=>
        (interleave || addr_out[IDX_W-1:0] == IDX_W'($past(addr_out[IDX_W-1:0]) + 1'b1))); // R4

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !load) |=> $stable(addr_out[ADDR_W-1:IDX_W])); // R6

    AST_HOLD_NO_CLKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en) |=> (!$stable(interleave) || $stable(addr_out))); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !load && !advance) |=> (!$stable(interleave) || $stable(addr_out))); // R10

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .load       (load),
    .advance    (advance),
    .start_addr (start_addr),
    .interleave (interleave),
    .addr_out   (addr_out)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

    localparam int AW = 8;
    localparam int NV = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b0;
    logic          load = 1'b0;
    logic          advance = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          interleave = 1'b1;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .IDX_W(2)) u_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .load(load),
        .advance(advance), .start_addr(start_addr),
        .interleave(interleave), .addr_out(addr_out)
    );

    // {clk_en, load, advance, interleave, start, expected, requirement}
    localparam logic [23:0] VEC [0:NV-1] = '{
        {4'b1101, 8'hA6, 8'hA6, 4'd2},  // R2 load, interleaved
        {4'b1011, 8'h00, 8'hA7, 4'd3},  // R3 beat 1
        {4'b1011, 8'h00, 8'hA4, 4'd3},  // R3 beat 2
        {4'b1011, 8'h00, 8'hA5, 4'd3},  // R3 beat 3
        {4'b1011, 8'h00, 8'hA6, 4'd5},  // R5 wrap
        {4'b1100, 8'h3B, 8'h3B, 4'd2},  // R2 load, linear
        {4'b1010, 8'h00, 8'h38, 4'd4},  // R4 beat 1, carry dropped
        {4'b1010, 8'h00, 8'h39, 4'd4},  // R4 beat 2
        {4'b1010, 8'h00, 8'h3A, 4'd6},  // R6 upper bits kept
        {4'b1010, 8'h00, 8'h3B, 4'd5},  // R5 wrap
        {4'b1010, 8'h00, 8'h38, 4'd4},  // R4 beat 1 again
        {4'b0110, 8'hFF, 8'h38, 4'd7},  // R7 enable low
        {4'b1000, 8'hFF, 8'h38, 4'd10}, // R10 idle
        {4'b1110, 8'h51, 8'h51, 4'd8},  // R8 load beats advance
        {4'b1010, 8'h00, 8'h52, 4'd4},  // R4 linear beat 1
        {4'b1001, 8'h00, 8'h50, 4'd9},  // R9 flip to interleaved
        {4'b1000, 8'h00, 8'h52, 4'd9},  // R9 flip back
        {4'b1011, 8'h00, 8'h53, 4'd3}   // R3 beat 2 after flip
    };

    task automatic check(input logic [AW-1:0] exp, input int req, input string what);
        checks++;
        if (addr_out !== exp) begin
            errors++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, addr_out, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        // R1 reset state
        repeat (2) @(posedge clk);
        #1 check('0, 1, "reset state");
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {clk_en, load, advance, interleave} = VEC[i][23:20];
            start_addr = VEC[i][19:12];
            @(posedge clk);
            #1 check(VEC[i][11:4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
        end

        // R1 reset mid-burst clears the address
        @(negedge clk);
        {clk_en, load, advance, interleave} = 4'b1011;
        rst_n = 1'b0;
        @(posedge clk);
        #1 check('0, 1, "reset mid-burst");

        // R3 full interleaved burst from low bits 11 with upper all ones
        @(negedge clk);
        rst_n = 1'b1;
        {clk_en, load, advance, interleave} = 4'b1101;
        start_addr = 8'hFF;
        @(posedge clk);
        #1 check(8'hFF, 2, "load top address");
        @(negedge clk) {load, advance} = 2'b01;
        @(posedge clk); #1 check(8'hFE, 3, "xor beat 1");
        @(posedge clk); #1 check(8'hFD, 3, "xor beat 2");
        @(posedge clk); #1 check(8'hFC, 3, "xor beat 3");
        @(posedge clk); #1 check(8'hFF, 5, "xor wrap");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule